// File: doc/BRIEF.md
# Dual-Mode Peripheral Bus Interface

This block is the register-access front end of a small peripheral. A host bus
arrives on asynchronous pins. A static mode input chooses how two control pins
are read. With the mode high, one pin is an active-high data strobe and the
other is a read/write direction line. With the mode low, the same strobe pin is
an active-low read strobe that acts as an output enable, and the direction pin
becomes an active-low write strobe.

Both control pins pass through a two-flop synchronizer clocked by a fast system
clock. The control logic finds the start of each read window and the end of
each write. It then issues one-cycle requests to the register file behind it,
together with the address and the write data it has captured. Read data comes
back from the register file in the same cycle as the request. It is held and
presented with an output enable for as long as the read window lasts. An
active-low lockout input stops all access and forces the output enable low.

Top module: `dual_bus_front`

## Requirements
- R1: `modeSel` high selects the strobe-plus-direction style. `modeSel` low selects the separate-strobes style. The mode is held static while out of reset.
- R2: Strobe-plus-direction read: `busStrobe` high with `busDir` high gives one `regRd` pulse carrying the bus address. `dataOe` then stays high until the synchronized strobe falls.
- R3: Strobe-plus-direction write: a falling edge of `busStrobe` while `busDir` is low gives exactly one `regWr` pulse with the captured address and data. A falling strobe with `busDir` high gives no write.
- R4: Separate-strobes read: `busStrobe` low (active-low read strobe) gives one `regRd` pulse. `dataOe` then stays high while the strobe stays low.
- R5: Separate-strobes write: a rising edge of `busDir` (active-low write strobe) gives exactly one `regWr` pulse with the captured address and data.
- R6: While `lockN` is low, no `regRd` or `regWr` pulse is issued.
- R7: `dataOe` is low whenever no read window is open. It is also low in any cycle in which `lockN` is low, with no delay.
- R8: A pin change sampled at clock edge m shows up as a request pulse in the cycle after edge m+2. `dataOe` rises one cycle after `regRd`.
- R9: A low `rstN` sampled at a clock edge clears `regRd`, `regWr` and `dataOe`. The synchronizers are preset to the idle level of the selected mode, so leaving reset issues no request.
- R10: While `dataOe` is high, `dataOut` holds the `regRdData` value that was present during the `regRd` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus strobes |
| rstN | input | 1 | Synchronous active-low reset |
| modeSel | input | 1 | 1: strobe plus direction, 0: separate read/write strobes |
| lockN | input | 1 | Active-low access lockout, synchronous to clk |
| busStrobe | input | 1 | Data strobe (mode 1) or active-low read strobe (mode 0) |
| busDir | input | 1 | Read/write direction (mode 1) or active-low write strobe (mode 0) |
| busAddr | input | ADDR_W | Bus address |
| busData | input | DATA_W | Bus write data |
| dataOut | output | DATA_W | Read data driven toward the bus pads |
| dataOe | output | 1 | Output enable for the bus pads |
| regRd | output | 1 | One-cycle register read request |
| regWr | output | 1 | One-cycle register write request |
| regAddr | output | ADDR_W | Address of the request |
| regWrData | output | DATA_W | Write data of the request |
| regRdData | input | DATA_W | Read data returned in the `regRd` cycle |

## Verification
Some properties are checked on every cycle. Each request is a single-cycle pulse. No request follows a lockout cycle. The output enable is never high during lockout. It only rises in the cycle right after a read request. Reset clears all outputs.

The bench's scenarios are needed to show the rest. This covers the exact three-edge latency and the mode-dependent meaning of the two strobe pins. It also covers that the captured address and data match the bus, that read data is held through the window, and that a read-direction strobe never produces a write.

// File: rtl/busfe_pkg.sv
package busfe_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;   // bus address/data are valid this cycle
    logic issueRd;   // one-cycle read request
    logic issueWr;   // one-cycle write request
    logic driveBus;  // enable the read data onto the bus
  } busCtlT;

endpackage

// File: rtl/busfe_sync.sv
module busfe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic idleVal,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= {STAGES{idleVal}};
    else       chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/busfe_ctrl.sv
module busfe_ctrl
  import busfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   modeSel,
  input  logic   lockN,
  input  logic   busStrobe,
  input  logic   busDir,
  output busCtlT ctl
);
  logic strbSync, dirSync;
  logic strbPrev, dirPrev;
  logic winQ, rdReq, wrReq, oeQ;
  logic readWin, wrEdge, active;

  // In either mode the direction pin idles high; the strobe idles low
  // only in the strobe-plus-direction style.
  busfe_sync #(.STAGES(SYNC_STAGES)) u_syncStrb (
    .clk(clk), .rstN(rstN), .idleVal(~modeSel), .din(busStrobe), .dout(strbSync)
  );
  busfe_sync #(.STAGES(SYNC_STAGES)) u_syncDir (
    .clk(clk), .rstN(rstN), .idleVal(1'b1), .din(busDir), .dout(dirSync)
  );

  always_comb begin
    if (modeSel) begin
      readWin = strbSync && dirSync;
      wrEdge  = strbPrev && !strbSync && !dirPrev;
      active  = strbSync;
    end else begin
      readWin = !strbSync;
      wrEdge  = dirSync && !dirPrev;
      active  = !strbSync || !dirSync;
    end
    readWin = readWin && lockN;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strbPrev <= ~modeSel;
      dirPrev  <= 1'b1;
      winQ     <= 1'b0;
      rdReq    <= 1'b0;
      wrReq    <= 1'b0;
      oeQ      <= 1'b0;
    end else begin
      strbPrev <= strbSync;
      dirPrev  <= dirSync;
      winQ     <= readWin;
      rdReq    <= readWin && !winQ;
      wrReq    <= wrEdge && lockN;
      oeQ      <= (rdReq || oeQ) && readWin;
    end
  end

  always_comb begin
    ctl.capture  = active;
    ctl.issueRd  = rdReq;
    ctl.issueWr  = wrReq;
    ctl.driveBus = oeQ && lockN;
  end
endmodule

// File: rtl/busfe_dpath.sv
module busfe_dpath
  import busfe_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtlT            ctl,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              regRd,
  output logic              regWr
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (ctl.capture) begin
        addrQ  <= busAddr;
        wdataQ <= busData;
      end
      if (ctl.issueRd) rdataQ <= regRdData;
    end
  end

  assign regAddr   = addrQ;
  assign regWrData = wdataQ;
  assign regRd     = ctl.issueRd;
  assign regWr     = ctl.issueWr;
  assign dataOe    = ctl.driveBus;
  assign dataOut   = ctl.driveBus ? rdataQ : '0;
endmodule

// File: rtl/dual_bus_front.sv
module dual_bus_front
  import busfe_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic              lockN,
  input  logic              busStrobe,
  input  logic              busDir,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              regRd,
  output logic              regWr,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] regRdData
);
  busCtlT ctl;

  busfe_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .lockN(lockN),
    .busStrobe(busStrobe), .busDir(busDir), .ctl(ctl)
  );

  busfe_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .busAddr(busAddr), .busData(busData),
    .regRdData(regRdData), .regAddr(regAddr), .regWrData(regWrData),
    .dataOut(dataOut), .dataOe(dataOe), .regRd(regRd), .regWr(regWr)
  );
endmodule

// File: rtl/busfe_chk.sv
module busfe_chk (
  input logic clk,
  input logic rstN,
  input logic lockN,
  input logic regRd,
  input logic regWr,
  input logic dataOe
);
  a_r3_wr_single: assert property (@(posedge clk) disable iff (!rstN)
    regWr |=> !regWr);

  a_r2_rd_single: assert property (@(posedge clk) disable iff (!rstN)
    regRd |=> !regRd);

  a_r6_lock_blocks: assert property (@(posedge clk) disable iff (!rstN)
    !lockN |=> (!regRd && !regWr));

  a_r7_oe_lock: assert property (@(posedge clk) disable iff (!rstN)
    !lockN |-> !dataOe);

  a_r8_oe_after_rd: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> $past(regRd));

  a_r9_reset_clear: assert property (@(posedge clk)
    !rstN |=> (!regRd && !regWr && !dataOe));
endmodule

bind dual_bus_front busfe_chk u_chk (
  .clk(clk), .rstN(rstN), .lockN(lockN),
  .regRd(regRd), .regWr(regWr), .dataOe(dataOe)
);

// File: tb/dual_bus_front_tb.sv
module dual_bus_front_tb;
  localparam int AW = 6;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b1;
  logic lockN = 1'b1;
  logic busStrobe = 1'b0;
  logic busDir = 1'b1;
  logic [AW-1:0] busAddr = '0;
  logic [DW-1:0] busData = '0;
  logic [DW-1:0] dataOut, regWrData, regRdData;
  logic [AW-1:0] regAddr;
  logic dataOe, regRd, regWr;

  int checks = 0;
  int errors = 0;
  int rdCount = 0;
  int wrCount = 0;
  bit done = 1'b0;

  // transaction the bench is currently running
  logic [AW-1:0] expAddr = '0;
  logic [DW-1:0] expData = '0;

  // behavioural model state
  bit hDs[4];
  bit hRw[4];
  bit hLk[4];
  bit mWinQ = 0, mRd = 0, mWr = 0, mOe = 0;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] regFile(input logic [AW-1:0] a);
    return DW'(a * 7 + 8'h21);
  endfunction

  assign regRdData = regFile(regAddr);

  dual_bus_front #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .lockN(lockN),
    .busStrobe(busStrobe), .busDir(busDir), .busAddr(busAddr), .busData(busData),
    .dataOut(dataOut), .dataOe(dataOe), .regRd(regRd), .regWr(regWr),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // model update at each edge, compare shortly after it
  always @(posedge clk) begin
    bit win, nRd, nWr, nOe;
    for (int k = 3; k > 0; k--) begin
      hDs[k] = hDs[k-1]; hRw[k] = hRw[k-1]; hLk[k] = hLk[k-1];
    end
    hDs[0] = busStrobe; hRw[0] = busDir; hLk[0] = lockN;
    if (!rstN) begin
      mWinQ = 0; mRd = 0; mWr = 0; mOe = 0;
    end else begin
      win = (modeSel ? (hDs[2] && hRw[2]) : !hDs[2]) && hLk[0];
      nRd = win && !mWinQ;
      nOe = (mRd || mOe) && win;
      nWr = (modeSel ? (hDs[3] && !hDs[2] && !hRw[3]) : (!hRw[3] && hRw[2])) && hLk[0];
      mWinQ = win; mRd = nRd; mOe = nOe; mWr = nWr;
    end
    #1;
    if (rstN) begin
      // R8 latency of the request pulses, R2/R4 reads, R3/R5 writes
      check(regRd == mRd, "R8", "regRd timing", regRd, mRd);
      check(regWr == mWr, "R8", "regWr timing", regWr, mWr);
      // R7 output enable window and lockout
      check(dataOe == (mOe && lockN), "R7", "dataOe", dataOe, mOe && lockN);
      if (regRd) begin
        rdCount++;
        check(regAddr == expAddr, "R2", "read address", regAddr, expAddr);
      end
      if (regWr) begin
        wrCount++;
        check(regAddr == expAddr, "R3", "write address", regAddr, expAddr);
        check(regWrData == expData, "R5", "write data", regWrData, expData);
      end
      if (dataOe)
        check(dataOut == regFile(expAddr), "R10", "dataOut", dataOut, regFile(expAddr));
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input bit m);
    @(negedge clk);
    rstN = 1'b0;
    modeSel = m;
    busStrobe = ~m;
    busDir = 1'b1;
    idle(5);
    rstN = 1'b1;
    idle(2);
    // R9 outputs clear and no spurious request after reset
    check(!regRd && !regWr && !dataOe, "R9", "outputs after reset",
          {regRd, regWr, dataOe}, 0);
  endtask

  task automatic motRead(input logic [AW-1:0] a);
    expAddr = a; busAddr = a; busDir = 1'b1;
    idle(1); busStrobe = 1'b1;
    idle(8); busStrobe = 1'b0;
    idle(5);
  endtask

  task automatic motWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    expAddr = a; expData = d; busAddr = a; busData = d; busDir = 1'b0;
    idle(1); busStrobe = 1'b1;
    idle(6); busStrobe = 1'b0;
    idle(5); busDir = 1'b1;
    idle(1);
  endtask

  task automatic intRead(input logic [AW-1:0] a);
    expAddr = a; busAddr = a;
    idle(1); busStrobe = 1'b0;
    idle(8); busStrobe = 1'b1;
    idle(5);
  endtask

  task automatic intWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    expAddr = a; expData = d; busAddr = a; busData = d;
    idle(1); busDir = 1'b0;
    idle(6); busDir = 1'b1;
    idle(5);
  endtask

  initial begin
    int r0, w0;
    for (int k = 0; k < 4; k++) begin hDs[k] = 0; hRw[k] = 1; hLk[k] = 1; end
    // reset state
    idle(2);
    check(!regRd && !regWr && !dataOe, "R9", "outputs in reset",
          {regRd, regWr, dataOe}, 0);

    // R1 strobe-plus-direction style
    doReset(1'b1);
    r0 = rdCount;
    motRead(6'h15);
    check(rdCount == r0 + 1, "R2", "one read per strobe", rdCount, r0 + 1);
    w0 = wrCount;
    motWrite(6'h2A, 8'hC3);
    check(wrCount == w0 + 1, "R3", "one write per strobe", wrCount, w0 + 1);
    w0 = wrCount;
    motRead(6'h01);
    check(wrCount == w0, "R3", "read strobe end makes no write", wrCount, w0);
    motWrite(6'h3F, 8'h00);
    motRead(6'h3F);

    // R6 lockout in strobe-plus-direction style
    r0 = rdCount; w0 = wrCount;
    @(negedge clk) lockN = 1'b0;
    motRead(6'h07);
    motWrite(6'h08, 8'h5A);
    check(rdCount == r0 && wrCount == w0, "R6", "lockout blocks access",
          rdCount + wrCount, r0 + w0);
    lockN = 1'b1;
    idle(3);

    // R7 lockout raised in the middle of a read window
    expAddr = 6'h11; busAddr = 6'h11; busDir = 1'b1;
    idle(1); busStrobe = 1'b1;
    idle(7);
    check(dataOe == 1'b1, "R2", "window open", dataOe, 1);
    lockN = 1'b0;
    #0.5;
    check(dataOe == 1'b0, "R7", "dataOe drops at lockout", dataOe, 0);
    idle(2); busStrobe = 1'b0; lockN = 1'b1;
    idle(6);

    // R1 separate-strobes style
    doReset(1'b0);
    r0 = rdCount;
    intRead(6'h22);
    check(rdCount == r0 + 1, "R4", "one read per strobe", rdCount, r0 + 1);
    w0 = wrCount;
    intWrite(6'h33, 8'hA5);
    check(wrCount == w0 + 1, "R5", "one write per strobe", wrCount, w0 + 1);
    intWrite(6'h00, 8'hFF);
    intRead(6'h3E);

    // R6 lockout in separate-strobes style
    r0 = rdCount; w0 = wrCount;
    @(negedge clk) lockN = 1'b0;
    intRead(6'h05);
    intWrite(6'h06, 8'h99);
    check(rdCount == r0 && wrCount == w0, "R6", "lockout blocks access",
          rdCount + wrCount, r0 + w0);
    lockN = 1'b1;
    idle(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule